// File: doc/BRIEF.md
# Triggered Conversion Sequencer with Dual Current

This block runs one host-triggered conversion on a converter modelled by a start/end-of-conversion handshake. On a request it latches the channel, turns the two requested bias currents (for channel 0 and channel 3) into two-bit source codes, and drives the converter controls in a fixed order. First come the delay-extension bit and the current codes, then the force-on bit, then the channel number with the conversion enable, and last a one-cycle start pulse with the end-of-conversion event unmasked. It then waits for the end-of-conversion strobe, bounded by a cycle timeout. It keeps the low 12 bits of the two-byte data word and releases the converter.

When dual-current mode is requested on channel 3, a second conversion follows. It runs with the channel 3 current code raised by one step and its result goes to a second output. The sequencer refuses dual mode when the code is already at the top step. On completion or timeout it spends one release cycle with `done` high. In that cycle the channel select is cleared, force is off and the end-of-conversion event is masked again.

States: `S_IDLE` (waits; request accepted → `S_CFG`), `S_CFG` (codes driven → `S_FORCE`), `S_FORCE` (force on → `S_SEL`), `S_SEL` (channel and enable → `S_START`), `S_START` (start pulse → `S_WAIT`), `S_WAIT` (end of conversion → `S_BUMP` if a second pass is due, otherwise `S_FIN`; timeout → `S_FIN`), `S_BUMP` (channel 3 code + 1 → `S_START`), `S_FIN` (release, `done` → `S_IDLE`).

Top module: `conv_seq`

## Requirements
- R1: After reset `busy`, `done`, `cv_force`, `cv_sel_en`, `cv_start`, `res1_valid` and `timeout_err` are 0, `cv_chan`, `res0`, `res1` and both source codes are 0, and `cv_eoc_mask` is 1.
- R2: The channel 0 source code is 0 for 0 µA, 1 (5 µA) for 1..5, 2 (15 µA) for 6..15 and 3 (20 µA) above 15. It is latched when the request is accepted.
- R3: The channel 3 source code is 0 for 0 µA, 1 (10 µA) for 1..10, 2 (400 µA) for 11..400 and 3 (800 µA) above 400. It is latched when the request is accepted.
- R4: A request accepted at clock edge k leads to `S_CFG` after k. Force goes high one cycle later, channel plus enable one cycle after that, and `cv_start` is high for exactly one cycle after that, with `cv_eoc_mask` low from the start cycle until the release.
- R5: An end-of-conversion strobe sampled in `S_WAIT` stores `cv_data[11:0]` as the result of that pass.
- R6: If no strobe arrives within `TIMEOUT_CYC` wait cycles, `timeout_err` is set and the sequencer releases. A strobe in the last allowed wait cycle still counts as success.
- R7: With dual mode on channel 3 and a code below 3, a second pass runs with the channel 3 code plus one. Its result appears on `res1` with `res1_valid` = 1.
- R8: Dual mode has no effect when the channel 3 code is 3 or the channel is not 3: one pass runs and `res1_valid` stays 0.
- R9: Every sequence ends with one cycle of `done` = 1, `cv_force` = 0, `cv_sel_en` = 0, `cv_chan` = 0 and `cv_eoc_mask` = 1, then returns to idle. Results and error hold until the next accepted request clears them.
- R10: A request while `busy` is ignored, and so is an end-of-conversion strobe outside `S_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Conversion request (taken when idle) |
| req_chan | input | CHW | Channel to convert |
| req_ch0_ua | input | UAW | Requested channel 0 bias current in µA |
| req_ch3_ua | input | UAW | Requested channel 3 bias current in µA |
| req_dual | input | 1 | Ask for a second pass at the next channel 3 step |
| req_ext_delay | input | 1 | Extended settling delay setting |
| cv_eoc | input | 1 | End-of-conversion strobe from converter |
| cv_data | input | DW | Two-byte conversion data word |
| cv_ext_delay | output | 1 | Extended delay setting to converter |
| cv_src0_code | output | 2 | Channel 0 current source code |
| cv_src3_code | output | 2 | Channel 3 current source code |
| cv_force | output | 1 | Force converter on |
| cv_sel_en | output | 1 | Conversion enable beside channel select |
| cv_chan | output | CHW | Selected channel (0 when not selected) |
| cv_start | output | 1 | One-cycle start pulse |
| cv_eoc_mask | output | 1 | End-of-conversion event mask (1 = masked) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| res0 | output | RW | First pass result |
| res1 | output | RW | Second pass result |
| res1_valid | output | 1 | Second pass result present |
| timeout_err | output | 1 | A pass timed out |

## Verification
A wrong state in the sequencer shows on the converter controls within one cycle. A skipped or repeated step moves the force, select or start edges, and a stuck wait shows up as a missing `done` or a timeout at the wrong cycle. A wrong latched code or pass flag appears on the source code outputs at the first configuration cycle, or as a missing or extra start pulse for the second pass. Comparing every output against the bench model on every clock catches any of these at the cycle they occur, and the timeout boundary is probed one cycle either side of the limit.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CFG, S_FORCE, S_SEL, S_START, S_WAIT, S_BUMP, S_FIN
    } seq_state_t;

    typedef logic [1:0] src_code_t;

    localparam src_code_t SRC_TOP = 2'd3;
endpackage

// File: rtl/cur_encode.sv
module cur_encode
    import convseq_pkg::*;
#(
    parameter int UAW = 10,
    parameter int T1  = 5,
    parameter int T2  = 15
) (
    input  logic [UAW-1:0] ua,
    output src_code_t      code
);
    // smallest step at or above the request, saturating at the top step
    always_comb begin
        if (ua == '0)
            code = 2'd0;
        else if (ua <= UAW'(T1))
            code = 2'd1;
        else if (ua <= UAW'(T2))
            code = 2'd2;
        else
            code = SRC_TOP;
    end
endmodule

// File: rtl/eoc_timer.sv
module eoc_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // count never passes the last allowed wait cycle
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import convseq_pkg::*;
#(
    parameter int CHW         = 4,
    parameter int UAW         = 10,
    parameter int DW          = 16,
    parameter int RW          = 12,
    parameter int TIMEOUT_CYC = 1000000,
    parameter int DUAL_CHAN   = 3,
    parameter int CH0_T1      = 5,
    parameter int CH0_T2      = 15,
    parameter int CH3_T1      = 10,
    parameter int CH3_T2      = 400
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [CHW-1:0] req_chan,
    input  logic [UAW-1:0] req_ch0_ua,
    input  logic [UAW-1:0] req_ch3_ua,
    input  logic           req_dual,
    input  logic           req_ext_delay,
    input  logic           cv_eoc,
    input  logic [DW-1:0]  cv_data,
    output logic           cv_ext_delay,
    output logic [1:0]     cv_src0_code,
    output logic [1:0]     cv_src3_code,
    output logic           cv_force,
    output logic           cv_sel_en,
    output logic [CHW-1:0] cv_chan,
    output logic           cv_start,
    output logic           cv_eoc_mask,
    output logic           busy,
    output logic           done,
    output logic [RW-1:0]  res0,
    output logic [RW-1:0]  res1,
    output logic           res1_valid,
    output logic           timeout_err
);
    localparam logic [CHW-1:0] DCH = CHW'(DUAL_CHAN);

    seq_state_t     state_q, state_d;
    src_code_t      enc0, enc3;
    src_code_t      code0_q, code3_q;
    logic [CHW-1:0] chan_q;
    logic           ext_q, dual_q, pass_q;
    logic [RW-1:0]  res0_q, res1_q;
    logic           r1v_q, err_q;
    logic           expired, accept;
    logic           data_hi_unused;

    assign data_hi_unused = ^cv_data[DW-1:RW];
    assign accept = (state_q == S_IDLE) && req;

    cur_encode #(.UAW(UAW), .T1(CH0_T1), .T2(CH0_T2)) u_enc0 (
        .ua(req_ch0_ua), .code(enc0));
    cur_encode #(.UAW(UAW), .T1(CH3_T1), .T2(CH3_T2)) u_enc3 (
        .ua(req_ch3_ua), .code(enc3));

    eoc_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == S_START),
        .run(state_q == S_WAIT),
        .expired(expired));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req) state_d = S_CFG;
            S_CFG:   state_d = S_FORCE;
            S_FORCE: state_d = S_SEL;
            S_SEL:   state_d = S_START;
            S_START: state_d = S_WAIT;
            S_WAIT: begin
                if (cv_eoc)
                    state_d = (!pass_q && dual_q) ? S_BUMP : S_FIN;
                else if (expired)
                    state_d = S_FIN;
            end
            S_BUMP:  state_d = S_START;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // latched request, pass tracking and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q  <= '0;
            code0_q <= '0;
            code3_q <= '0;
            ext_q   <= 1'b0;
            dual_q  <= 1'b0;
            pass_q  <= 1'b0;
            res0_q  <= '0;
            res1_q  <= '0;
            r1v_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            chan_q  <= req_chan;
            code0_q <= enc0;
            code3_q <= enc3;
            ext_q   <= req_ext_delay;
            dual_q  <= req_dual && (req_chan == DCH) && (enc3 != SRC_TOP);
            pass_q  <= 1'b0;
            res0_q  <= '0;
            res1_q  <= '0;
            r1v_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (state_q == S_WAIT) begin
            if (cv_eoc) begin
                if (!pass_q) begin
                    res0_q <= cv_data[RW-1:0];
                end else begin
                    res1_q <= cv_data[RW-1:0];
                    r1v_q  <= 1'b1;
                end
            end else if (expired) begin
                err_q <= 1'b1;
            end
        end else if (state_q == S_BUMP) begin
            code3_q <= code3_q + 2'd1;
            pass_q  <= 1'b1;
        end
    end

    // converter controls and status
    always_comb begin
        cv_force    = 1'b0;
        cv_sel_en   = 1'b0;
        cv_start    = 1'b0;
        cv_eoc_mask = 1'b1;
        busy        = 1'b1;
        done        = 1'b0;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_CFG:   ;
            S_FORCE: cv_force = 1'b1;
            S_SEL: begin
                cv_force  = 1'b1;
                cv_sel_en = 1'b1;
            end
            S_START: begin
                cv_force    = 1'b1;
                cv_sel_en   = 1'b1;
                cv_start    = 1'b1;
                cv_eoc_mask = 1'b0;
            end
            S_WAIT, S_BUMP: begin
                cv_force    = 1'b1;
                cv_sel_en   = 1'b1;
                cv_eoc_mask = 1'b0;
            end
            S_FIN:   done = 1'b1;
            default: busy = 1'b0;
        endcase
        cv_chan      = cv_sel_en ? chan_q : '0;
        cv_ext_delay = ext_q;
        cv_src0_code = code0_q;
        cv_src3_code = code3_q;
        res0         = res0_q;
        res1         = res1_q;
        res1_valid   = r1v_q;
        timeout_err  = err_q;
    end

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> !cv_start);
    assert_sel_under_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cv_sel_en |-> cv_force);
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cv_force && !cv_sel_en && cv_eoc_mask && cv_chan == '0));
    assert_bump_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUMP) |=> (cv_src3_code == $past(cv_src3_code) + 2'd1));
    assert_refuse_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUMP) |-> (cv_src3_code != SRC_TOP));
    assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cv_src0_code));
endmodule

// File: tb/conv_seq_tb.sv
`timescale 1ns/1ps
module conv_seq_tb;
    localparam int TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  req_chan = '0;
    logic [9:0]  req_ch0_ua = '0, req_ch3_ua = '0;
    logic        req_dual = 1'b0, req_ext_delay = 1'b0;
    logic        cv_eoc = 1'b0;
    logic [15:0] cv_data = '0;
    logic        cv_ext_delay, cv_force, cv_sel_en, cv_start, cv_eoc_mask;
    logic [1:0]  cv_src0_code, cv_src3_code;
    logic [3:0]  cv_chan;
    logic        busy, done, res1_valid, timeout_err;
    logic [11:0] res0, res1;

    always #2.5 clk = ~clk;

    conv_seq #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan),
        .req_ch0_ua(req_ch0_ua), .req_ch3_ua(req_ch3_ua), .req_dual(req_dual),
        .req_ext_delay(req_ext_delay), .cv_eoc(cv_eoc), .cv_data(cv_data),
        .cv_ext_delay(cv_ext_delay), .cv_src0_code(cv_src0_code),
        .cv_src3_code(cv_src3_code), .cv_force(cv_force), .cv_sel_en(cv_sel_en),
        .cv_chan(cv_chan), .cv_start(cv_start), .cv_eoc_mask(cv_eoc_mask),
        .busy(busy), .done(done), .res0(res0), .res1(res1),
        .res1_valid(res1_valid), .timeout_err(timeout_err));

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int step_of(int ua, int s1, int s2, int s3);
        int steps[4];
        steps = '{0, s1, s2, s3};
        for (int i = 0; i < 4; i++)
            if (ua <= steps[i]) return i;
        return 3;
    endfunction

    // converter model
    int lat1, lat2, d1, d2, starts, cd;
    bit cd_act = 0, spur = 0;
    always @(negedge clk) begin
        cv_eoc = 1'b0;
        if (cd_act) begin
            if (cd == 0) begin cv_eoc = 1'b1; cd_act = 0; end
            else cd--;
        end
        if (cv_start) begin
            int l;
            l = (starts == 0) ? lat1 : lat2;
            cv_data = 16'((starts == 0) ? d1 : d2);
            starts++;
            if (l >= 0) begin cd = l; cd_act = 1; end
        end
        if (spur) cv_eoc = 1'b1;
    end

    // behavioural reference: phase 0 idle,1 cfg,2 force,3 select,4 start,5 wait,6 step-up,7 release
    int m_ph, m_wc, m_chan, m_c0, m_c3, m_res0, m_res1;
    bit m_ext, m_dual, m_second, m_r1v, m_err;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wc = 0; m_chan = 0; m_c0 = 0; m_c3 = 0;
            m_res0 = 0; m_res1 = 0; m_ext = 0; m_dual = 0; m_second = 0;
            m_r1v = 0; m_err = 0;
        end else begin
            case (m_ph)
                0: if (req) begin
                    m_chan = req_chan;
                    m_c0 = step_of(req_ch0_ua, 5, 15, 20);
                    m_c3 = step_of(req_ch3_ua, 10, 400, 800);
                    m_ext = req_ext_delay;
                    m_dual = req_dual && req_chan == 3 && m_c3 < 3;
                    m_second = 0; m_res0 = 0; m_res1 = 0; m_r1v = 0; m_err = 0;
                    m_ph = 1;
                end
                4: begin m_wc = 0; m_ph = 5; end
                5: if (cv_eoc) begin
                    if (!m_second) m_res0 = cv_data & 16'hFFF;
                    else begin m_res1 = cv_data & 16'hFFF; m_r1v = 1; end
                    m_ph = (!m_second && m_dual) ? 6 : 7;
                end else if (m_wc == TO - 1) begin
                    m_err = 1; m_ph = 7;
                end else m_wc++;
                6: begin m_c3++; m_second = 1; m_ph = 4; end
                7: m_ph = 0;
                default: m_ph++;
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit f, s;
            f = m_ph >= 2 && m_ph <= 6;
            s = m_ph >= 3 && m_ph <= 6;
            chk("R4 force", cv_force, f);
            chk("R4 sel_en", cv_sel_en, s);
            chk("R4/R10 chan", cv_chan, s ? m_chan : 0);
            chk("R4 start", cv_start, m_ph == 4);
            chk("R4/R9 eoc_mask", cv_eoc_mask, !(m_ph >= 4 && m_ph <= 6));
            chk("R9/R10 busy", busy, m_ph != 0);
            chk("R9 done", done, m_ph == 7);
            chk("R2 src0", cv_src0_code, m_c0);
            chk("R3/R7 src3", cv_src3_code, m_c3);
            chk("R4 ext_delay", cv_ext_delay, m_ext);
            chk("R5 res0", res0, m_res0);
            chk("R7 res1", res1, m_res1);
            chk("R7/R8 res1_valid", res1_valid, m_r1v);
            chk("R6 timeout_err", timeout_err, m_err);
        end
    end

    task automatic run_txn(int ch, int ua0, int ua3, bit dual, bit ext,
                           int l1, int l2, int v1, int v2, bit mid_req);
        lat1 = l1; lat2 = l2; d1 = v1; d2 = v2; starts = 0;
        @(negedge clk);
        req = 1; req_chan = 4'(ch); req_ch0_ua = 10'(ua0); req_ch3_ua = 10'(ua3);
        req_dual = dual; req_ext_delay = ext;
        @(negedge clk);
        req = 0; req_ch0_ua = 10'd999; req_ch3_ua = 10'd999; req_ext_delay = ~ext;
        if (mid_req) begin
            req = 1; req_chan = 4'd9; req_dual = 1;
            @(negedge clk);
            req = 0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset mask", cv_eoc_mask, 1);
        chk("R1 reset force", cv_force, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 idle res0", res0, 0);
        chk("R1 idle err", timeout_err, 0);

        run_txn(5, 0, 0, 0, 0, 3, -1, 16'hABCD, 0, 0);
        chk("R5 low 12 bits", res0, 12'hBCD);
        run_txn(0, 3, 0, 0, 1, 0, -1, 16'h1234, 0, 0);
        chk("R2 ua=3 code", cv_src0_code, 1);
        chk("R5 fast eoc", res0, 12'h234);
        run_txn(1, 15, 10, 0, 0, 2, -1, 7, 0, 0);
        chk("R2 ua=15 code", cv_src0_code, 2);
        chk("R3 ua=10 code", cv_src3_code, 1);
        run_txn(1, 16, 11, 0, 0, 2, -1, 8, 0, 0);
        chk("R2 ua=16 code", cv_src0_code, 3);
        chk("R3 ua=11 code", cv_src3_code, 2);
        run_txn(2, 1000, 401, 0, 0, 1, -1, 9, 0, 0);
        chk("R2 ua=1000 code", cv_src0_code, 3);
        chk("R3 ua=401 code", cv_src3_code, 3);

        run_txn(3, 5, 10, 1, 0, 2, 4, 16'h0111, 16'hF222, 0);
        chk("R7 first", res0, 12'h111);
        chk("R7 second", res1, 12'h222);
        chk("R7 valid", res1_valid, 1);
        chk("R7 stepped code", cv_src3_code, 2);
        run_txn(3, 5, 800, 1, 0, 2, 2, 5, 6, 0);
        chk("R8 top step single pass", res1_valid, 0);
        chk("R8 top step starts", starts, 1);
        run_txn(4, 5, 10, 1, 0, 2, 2, 5, 6, 0);
        chk("R8 other channel single pass", starts, 1);

        run_txn(6, 0, 0, 0, 0, -1, -1, 0, 0, 0);
        chk("R6 no eoc timeout", timeout_err, 1);
        run_txn(6, 0, 0, 0, 0, TO - 1, -1, 16'h0ABC, 0, 0);
        chk("R6 last-cycle eoc ok", timeout_err, 0);
        chk("R6 last-cycle result", res0, 12'hABC);
        run_txn(6, 0, 0, 0, 0, TO, -1, 16'h0ABC, 0, 0);
        chk("R6 one cycle late", timeout_err, 1);
        chk("R6 late data ignored", res0, 0);
        run_txn(3, 0, 400, 1, 0, 1, -1, 16'h0321, 0, 0);
        chk("R6 second pass timeout", timeout_err, 1);
        chk("R6 first kept", res0, 12'h321);

        run_txn(7, 0, 0, 0, 0, 2, -1, 16'h0777, 0, 1);
        chk("R10 busy request ignored", res0, 12'h777);
        chk("R10 one pass only", starts, 1);
        @(negedge clk); spur = 1; cv_data = 16'h0555;
        @(negedge clk); spur = 0;
        repeat (2) @(negedge clk);
        chk("R10 idle eoc ignored", res0, 12'h777);
        chk("R9 holds after done", busy, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule